// File: doc/BRIEF.md
# Bit-Band Alias Access Converter

This block sits on the bus path between a single processor-side port and a memory-side port. Ordinary accesses go through it untouched: same address, data, strobes and direction, one memory transaction per processor transaction. Accesses that land in a 32 MB alias window are translated instead. Every alias word stands for exactly one bit of a 1 MB backing region, so software can test or change a single bit with an ordinary word load or store.

A load from the alias window becomes one read of the backing word. The addressed bit is returned in bit 0 of the read data, and every other bit is zero. A store to the alias window becomes a read followed by a write of the backing word. Only the addressed bit changes, and it takes the value of bit 0 of the store data. Both phases carry a lock indication so that no other traffic can slip in between them. While such a sequence runs, the processor port is held off.

Both ports use a request/ready handshake, with a transfer taking place in any cycle where request and ready are both high. A read response arrives as a one-cycle valid pulse. Only one access is in flight at a time.

Top module: `bitband_bridge`

## Requirements
- R1: An address outside the alias window is presented on the memory port in the same cycle, with the address, write flag, write data and byte strobes unchanged and lock low. It takes exactly one memory transaction, and its read data is returned unchanged.
- R2: The alias window is [ALIAS_BASE, ALIAS_BASE + 32 MB), defaulting to 0x2200_0000. For an alias offset `off`, the backing word address is REGION_BASE + ((off >> 7) << 2), with REGION_BASE defaulting to 0x2000_0000. The bit position inside that 32-bit little-endian word is off[6:2], so the byte lane is off[6:5] and the bit within the byte is off[4:2].
- R3: An alias load issues one unlocked memory read of the backing word. It returns the addressed bit in read-data bit 0, with bits 31:1 zero.
- R4: An alias store issues a read and then a write to the same backing word. The written word equals the word that was read with only the addressed bit replaced by store-data bit 0. Store-data bits 31:1 are ignored. With BYTE_STROBE=1 the write strobe is the single lane off[6:5] (value 1 << off[6:5]); otherwise all four lanes are set.
- R5: During an alias store, lock is high on the read phase, on every cycle between the two phases, and on the write phase.
- R6: From the cycle after an alias store's read phase is accepted until its write phase is accepted, the processor-side ready stays low.
- R7: The addresses just outside the window (ALIAS_BASE - 4 and ALIAS_BASE + 32 MB) are handled as ordinary pass-through accesses.
- R8: During reset the memory request, lock and processor read-valid are low when no processor request is present.
- R9: While the memory side holds ready low, a pending memory request stays asserted with a stable address and write flag. Results are unaffected by such stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request |
| cpu_we | input | 1 | Processor write flag |
| cpu_addr | input | AW | Processor byte address |
| cpu_wdata | input | DW | Processor write data |
| cpu_be | input | DW/8 | Processor byte strobes |
| cpu_ready | output | 1 | Request accepted when high together with cpu_req |
| cpu_rvalid | output | 1 | Read response valid (one cycle) |
| cpu_rdata | output | DW | Read response data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write flag |
| mem_lock | output | 1 | Locked (indivisible) sequence indication |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_be | output | DW/8 | Memory byte strobes |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Memory read response valid |
| mem_rdata | input | DW | Memory read response data |

## Verification
A pass-through request reaches the memory port combinationally, in the cycle it is presented. Every read answer, plain or single-bit, appears on the processor side in the same cycle as the memory response, which is one cycle after the memory read is accepted. An alias store needs the read acceptance, the response cycle and then the write acceptance, so the processor port reopens no earlier than three edges after the request. The bench drives on falling edges and samples one nanosecond after them. It waits for the read-valid and for ready to return instead of counting fixed delays, and it judges each operation only once ready has come back, including runs where the memory ready is throttled to one cycle in three.

// File: rtl/bb_pkg.sv
`timescale 1ns/1ps
package bb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PASS_RD,
      ST_BIT_RD,
      ST_RMW_RD,
      ST_RMW_WR
   } bb_state_e;

   localparam int ALIAS_EXPAND_LOG2 = 5;
endpackage

// File: rtl/bb_decode.sv
`timescale 1ns/1ps
module bb_decode #(
   parameter int           AW          = 32,
   parameter int           DW          = 32,
   parameter logic [AW-1:0] REGION_BASE = 32'h2000_0000,
   parameter logic [AW-1:0] ALIAS_BASE  = 32'h2200_0000,
   parameter int           REGION_LOG2 = 20,
   localparam int          IDX_W       = $clog2(DW),
   localparam int          LANE_W      = $clog2(DW/8)
) (
   input  logic [AW-1:0]    addr,
   output logic             hit,
   output logic [AW-1:0]    word_addr,
   output logic [IDX_W-1:0] bit_idx
);
   localparam int ALIAS_LOG2 = REGION_LOG2 + bb_pkg::ALIAS_EXPAND_LOG2;
   localparam logic [AW-1:0] ALIAS_MASK  = {AW{1'b1}} >> (AW - ALIAS_LOG2);
   localparam logic [AW-1:0] REGION_MASK = {AW{1'b1}} >> (AW - REGION_LOG2);

   if (ALIAS_LOG2 >= AW) begin : g_bad_span
      $error("alias window does not fit the address width");
   end
   if ((ALIAS_BASE & ALIAS_MASK) != '0) begin : g_bad_alias
      $error("alias base must be aligned to the window size");
   end
   if ((REGION_BASE & REGION_MASK) != '0) begin : g_bad_region
      $error("region base must be aligned to the region size");
   end

   logic [AW-1:0] off;

   always_comb begin
      off       = addr & ALIAS_MASK;
      hit       = (addr & ~ALIAS_MASK) == ALIAS_BASE;
      word_addr = REGION_BASE | ((off >> (IDX_W + 2)) << LANE_W);
      bit_idx   = off[IDX_W+1:2];
   end
endmodule

// File: rtl/bb_lane.sv
`timescale 1ns/1ps
module bb_lane #(
   parameter int  DW          = 32,
   parameter bit  BYTE_STROBE = 1'b1,
   localparam int BW          = DW / 8,
   localparam int IDX_W       = $clog2(DW)
) (
   input  logic [DW-1:0]    word,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic             new_bit,
   output logic             bit_val,
   output logic [DW-1:0]    merged,
   output logic [BW-1:0]    strobe
);
   always_comb begin
      bit_val         = word[bit_idx];
      merged          = word;
      merged[bit_idx] = new_bit;
   end

   if (BYTE_STROBE) begin : g_lane_strobe
      always_comb strobe = BW'(1) << bit_idx[IDX_W-1:3];
   end else begin : g_word_strobe
      always_comb strobe = '1;
   end
endmodule

// File: rtl/bb_ctrl.sv
`timescale 1ns/1ps
module bb_ctrl #(
   parameter int  AW    = 32,
   parameter int  DW    = 32,
   localparam int BW    = DW / 8,
   localparam int IDX_W = $clog2(DW)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_req,
   input  logic             cpu_we,
   input  logic [AW-1:0]    cpu_addr,
   input  logic [DW-1:0]    cpu_wdata,
   input  logic [BW-1:0]    cpu_be,
   output logic             cpu_ready,
   output logic             cpu_rvalid,
   output logic [DW-1:0]    cpu_rdata,
   output logic             mem_req,
   output logic             mem_we,
   output logic             mem_lock,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   output logic [BW-1:0]    mem_be,
   input  logic             mem_ready,
   input  logic             mem_rvalid,
   input  logic [DW-1:0]    mem_rdata,
   input  logic             dec_hit,
   input  logic [AW-1:0]    dec_word_addr,
   input  logic [IDX_W-1:0] dec_bit_idx,
   output logic [IDX_W-1:0] held_idx,
   output logic             held_bit,
   input  logic             lane_bit,
   input  logic [DW-1:0]    lane_merged,
   input  logic [BW-1:0]    lane_strobe
);
   import bb_pkg::*;

   bb_state_e     st_q, st_d;
   logic [AW-1:0] tgt_q;
   logic [DW-1:0] wr_q;
   logic          take;

   assign take = (st_q == ST_IDLE) && cpu_req && mem_ready;

   always_comb begin
      st_d       = st_q;
      mem_req    = 1'b0;
      mem_we     = 1'b0;
      mem_lock   = 1'b0;
      mem_addr   = tgt_q;
      mem_wdata  = wr_q;
      mem_be     = lane_strobe;
      cpu_ready  = 1'b0;
      cpu_rvalid = 1'b0;
      cpu_rdata  = mem_rdata;
      case (st_q)
         ST_IDLE: begin
            mem_req   = cpu_req;
            mem_addr  = dec_hit ? dec_word_addr : cpu_addr;
            mem_we    = cpu_we & ~dec_hit;
            mem_wdata = cpu_wdata;
            mem_be    = dec_hit ? {BW{1'b1}} : cpu_be;
            mem_lock  = cpu_req & dec_hit & cpu_we;
            cpu_ready = mem_ready;
            if (take) begin
               if (dec_hit) st_d = cpu_we ? ST_RMW_RD : ST_BIT_RD;
               else         st_d = cpu_we ? ST_IDLE   : ST_PASS_RD;
            end
         end
         ST_PASS_RD: begin
            cpu_rvalid = mem_rvalid;
            if (mem_rvalid) st_d = ST_IDLE;
         end
         ST_BIT_RD: begin
            cpu_rvalid = mem_rvalid;
            cpu_rdata  = DW'(lane_bit);
            if (mem_rvalid) st_d = ST_IDLE;
         end
         ST_RMW_RD: begin
            mem_lock = 1'b1;
            if (mem_rvalid) st_d = ST_RMW_WR;
         end
         ST_RMW_WR: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_lock = 1'b1;
            if (mem_ready) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         tgt_q    <= '0;
         wr_q     <= '0;
         held_idx <= '0;
         held_bit <= 1'b0;
      end else begin
         st_q <= st_d;
         if (take) begin
            tgt_q    <= dec_word_addr;
            held_idx <= dec_bit_idx;
            held_bit <= cpu_wdata[0];
         end
         if (st_q == ST_RMW_RD && mem_rvalid) begin
            wr_q <= lane_merged;
         end
      end
   end
endmodule

// File: rtl/bitband_bridge.sv
`timescale 1ns/1ps
module bitband_bridge #(
   parameter int            AW          = 32,
   parameter int            DW          = 32,
   parameter logic [AW-1:0] REGION_BASE = 32'h2000_0000,
   parameter logic [AW-1:0] ALIAS_BASE  = 32'h2200_0000,
   parameter int            REGION_LOG2 = 20,
   parameter bit            BYTE_STROBE = 1'b1,
   localparam int           BW          = DW / 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   input  logic [BW-1:0] cpu_be,
   output logic          cpu_ready,
   output logic          cpu_rvalid,
   output logic [DW-1:0] cpu_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic          mem_lock,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic [BW-1:0] mem_be,
   input  logic          mem_ready,
   input  logic          mem_rvalid,
   input  logic [DW-1:0] mem_rdata
);
   localparam int IDX_W = $clog2(DW);

   if (DW < 8 || (DW & (DW - 1)) != 0) begin : g_bad_dw
      $error("data width must be a power of two of at least 8");
   end

   logic             dec_hit;
   logic [AW-1:0]    dec_word_addr;
   logic [IDX_W-1:0] dec_bit_idx;
   logic [IDX_W-1:0] held_idx;
   logic             held_bit;
   logic             lane_bit;
   logic [DW-1:0]    lane_merged;
   logic [BW-1:0]    lane_strobe;

   bb_decode #(
      .AW(AW), .DW(DW), .REGION_BASE(REGION_BASE),
      .ALIAS_BASE(ALIAS_BASE), .REGION_LOG2(REGION_LOG2)
   ) u_decode (
      .addr(cpu_addr), .hit(dec_hit),
      .word_addr(dec_word_addr), .bit_idx(dec_bit_idx)
   );

   bb_lane #(.DW(DW), .BYTE_STROBE(BYTE_STROBE)) u_lane (
      .word(mem_rdata), .bit_idx(held_idx), .new_bit(held_bit),
      .bit_val(lane_bit), .merged(lane_merged), .strobe(lane_strobe)
   );

   bb_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
      .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
      .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .dec_hit(dec_hit), .dec_word_addr(dec_word_addr), .dec_bit_idx(dec_bit_idx),
      .held_idx(held_idx), .held_bit(held_bit),
      .lane_bit(lane_bit), .lane_merged(lane_merged), .lane_strobe(lane_strobe)
   );
endmodule

// File: rtl/bitband_bridge_chk.sv
`timescale 1ns/1ps
module bitband_bridge_chk #(
   parameter int            AW          = 32,
   parameter int            DW          = 32,
   parameter logic [AW-1:0] REGION_BASE = 32'h2000_0000,
   parameter logic [AW-1:0] ALIAS_BASE  = 32'h2200_0000,
   parameter int            REGION_LOG2 = 20,
   parameter bit            BYTE_STROBE = 1'b1,
   localparam int           BW          = DW / 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cpu_req,
   input logic          cpu_we,
   input logic [AW-1:0] cpu_addr,
   input logic [DW-1:0] cpu_wdata,
   input logic [BW-1:0] cpu_be,
   input logic          cpu_ready,
   input logic          cpu_rvalid,
   input logic [DW-1:0] cpu_rdata,
   input logic          mem_req,
   input logic          mem_we,
   input logic          mem_lock,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata,
   input logic [BW-1:0] mem_be,
   input logic          mem_ready,
   input logic          mem_rvalid,
   input logic [DW-1:0] mem_rdata
);
   localparam logic [AW:0] WIN_LO = {1'b0, ALIAS_BASE};
   localparam logic [AW:0] WIN_HI = WIN_LO + ((AW+1)'(1) << (REGION_LOG2 + 5));

   logic in_win;
   logic bit_rd_pending;

   assign in_win = ({1'b0, cpu_addr} >= WIN_LO) && ({1'b0, cpu_addr} < WIN_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_rd_pending <= 1'b0;
      else if (cpu_req && cpu_ready && !cpu_we) bit_rd_pending <= in_win;
      else if (cpu_rvalid) bit_rd_pending <= 1'b0;
   end

   // R1 and R7: pass-through accesses leave the memory port unaltered
   assert_pass_through_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_ready && !in_win) |->
      (mem_req && mem_addr == cpu_addr && mem_we == cpu_we &&
       mem_wdata == cpu_wdata && mem_be == cpu_be && !mem_lock));

   assert_bit_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rvalid && bit_rd_pending) |-> (cpu_rdata[DW-1:1] == '0));

   assert_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (BYTE_STROBE && mem_req && mem_we && mem_lock) |-> ($countones(mem_be) == 1));

   assert_lock_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ready && mem_lock && !mem_we) |=> mem_lock);

   assert_lock_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_lock && !mem_req) |=> mem_lock);

   assert_hold_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ready && mem_lock && !mem_we) |=> !cpu_ready);

   assert_stall_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   always @(posedge clk) begin
      if (!rst_n && !cpu_req) begin
         assert_reset_quiet_R8: assert (!mem_req && !mem_lock && !cpu_rvalid);
      end
   end
endmodule

bind bitband_bridge bitband_bridge_chk #(
   .AW(AW), .DW(DW), .REGION_BASE(REGION_BASE), .ALIAS_BASE(ALIAS_BASE),
   .REGION_LOG2(REGION_LOG2), .BYTE_STROBE(BYTE_STROBE)
) u_chk (.*);

// File: tb/tb_bitband_bridge.sv
`timescale 1ns/1ps
module tb_bitband_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [3:0]  cpu_be = '0;
   logic        cpu_ready, cpu_rvalid;
   logic [31:0] cpu_rdata;
   logic        mem_req, mem_we, mem_lock;
   logic [31:0] mem_addr, mem_wdata;
   logic [3:0]  mem_be;
   logic        mem_ready = 1'b1;
   logic        mem_rvalid;
   logic [31:0] mem_rdata;

   logic        stall_mode = 1'b0;
   logic [1:0]  scnt = '0;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   int          txn, lk, lock_gap, rdy_viol, stall_viol;
   logic [3:0]  last_be;
   bit          in_rmw, prev_stall;
   logic [31:0] prev_addr;
   logic [31:0] tmem [64];

   always #10 clk = ~clk;

   bitband_bridge dut (.*);

   // memory model: read data one cycle after acceptance
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_rvalid <= 1'b0;
         mem_rdata  <= '0;
         for (int i = 0; i < 64; i++) tmem[i] <= '0;
      end else begin
         mem_rvalid <= 1'b0;
         if (mem_req && mem_ready) begin
            if (mem_we) begin
               for (int b = 0; b < 4; b++)
                  if (mem_be[b]) tmem[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
               mem_rvalid <= 1'b1;
               mem_rdata  <= tmem[mem_addr[7:2]];
            end
         end
      end
   end

   always @(negedge clk) begin
      scnt      <= (scnt == 2'd2) ? 2'd0 : scnt + 2'd1;
      mem_ready <= stall_mode ? (scnt == 2'd2) : 1'b1;
   end

   // bus monitor
   initial begin
      txn = 0; lk = 0; lock_gap = 0; rdy_viol = 0; stall_viol = 0;
      last_be = '0; in_rmw = 0; prev_stall = 0; prev_addr = '0;
   end
   always @(posedge clk) begin
      if (rst_n) begin
         if (in_rmw && !mem_lock) lock_gap++;
         if (in_rmw && cpu_ready) rdy_viol++;
         if (prev_stall && (!mem_req || mem_addr != prev_addr)) stall_viol++;
         prev_stall = mem_req && !mem_ready;
         prev_addr  = mem_addr;
         if (mem_req && mem_ready) begin
            txn++;
            if (mem_lock) lk++;
            if (mem_we) last_be = mem_be;
            if (mem_lock && !mem_we) in_rmw = 1;
            if (mem_lock && mem_we) in_rmw = 0;
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit in_alias(input logic [31:0] a);
      return a >= 32'h2200_0000 && a < 32'h2400_0000;
   endfunction

   task automatic do_op(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be, output logic [31:0] rd);
      rd = '0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
      #1;
      while (!cpu_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0;
      #1;
      if (!we) begin
         while (!cpu_rvalid) begin @(negedge clk); #1; end
         rd = cpu_rdata;
      end
      while (!cpu_ready) begin @(negedge clk); #1; end
   endtask

   // {we, addr, wdata, be, expected (read data, or backing word after a write)}
   localparam logic [100:0] VEC [18] = '{
      {1'b1, 32'h2000_0000, 32'h0000_0000, 4'hF, 32'h0000_0000},
      {1'b1, 32'h2000_0004, 32'hA5A5_5A5A, 4'hF, 32'hA5A5_5A5A},
      {1'b0, 32'h2200_0000, 32'h0,         4'hF, 32'h0000_0000},
      {1'b1, 32'h2200_000C, 32'h0000_0001, 4'hF, 32'h0000_0008},
      {1'b0, 32'h2000_0000, 32'h0,         4'hF, 32'h0000_0008},
      {1'b1, 32'h2200_00DC, 32'hFFFF_FFFE, 4'hF, 32'hA525_5A5A},
      {1'b0, 32'h2000_0004, 32'h0,         4'hF, 32'hA525_5A5A},
      {1'b0, 32'h2200_0084, 32'h0,         4'hF, 32'h0000_0001},
      {1'b0, 32'h2200_0080, 32'h0,         4'hF, 32'h0000_0000},
      {1'b1, 32'h2200_00E0, 32'h0000_0001, 4'hF, 32'hA525_5A5A},
      {1'b1, 32'h2200_007C, 32'h0000_0003, 4'hF, 32'h8000_0008},
      {1'b0, 32'h2000_0000, 32'h0,         4'hF, 32'h8000_0008},
      {1'b0, 32'h2200_007C, 32'h0,         4'hF, 32'h0000_0001},
      {1'b1, 32'h2000_0008, 32'h1234_5678, 4'h2, 32'h0000_5600},
      {1'b0, 32'h2000_0008, 32'h0,         4'hF, 32'h0000_5600},
      {1'b1, 32'h21FF_FFFC, 32'hDEAD_BEEF, 4'hF, 32'hDEAD_BEEF},
      {1'b0, 32'h23FF_FFFC, 32'h0,         4'hF, 32'h0000_0001},
      {1'b0, 32'h2400_0000, 32'h0,         4'hF, 32'h8000_0008}
   };

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      #1;
      check("R8 mem_req in reset", {31'b0, mem_req}, 32'd0);
      check("R8 mem_lock in reset", {31'b0, mem_lock}, 32'd0);
      check("R8 cpu_rvalid in reset", {31'b0, cpu_rvalid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check("R8 idle after reset", {29'b0, mem_req, mem_lock, cpu_rvalid}, 32'd0);

      for (int k = 0; k < 18; k++) begin
         logic [100:0] v;
         logic         we, al;
         logic [31:0]  a, wd, ex;
         logic [3:0]   be;
         int           idx, lane;
         v = VEC[k];
         we = v[100]; a = v[99:68]; wd = v[67:36]; be = v[35:32]; ex = v[31:0];
         al = in_alias(a);
         idx  = al ? int'(((a - 32'h2200_0000) >> 7) & 63) : int'((a >> 2) & 63);
         lane = int'(((a - 32'h2200_0000) >> 5) & 3);
         txn = 0; lk = 0;
         do_op(we, a, wd, be, rd);
         if (!we) check(al ? "R2/R3 bit load" : "R1/R7 plain load", rd, ex);
         else     check(al ? "R2/R4 backing word" : "R1/R7 plain store", tmem[idx], ex);
         check(al && we ? "R4 two phases" : "R1/R3 one transaction",
               txn, (al && we) ? 32'd2 : 32'd1);
         check(al && we ? "R5 both phases locked" : "R1/R3 unlocked",
               lk, (al && we) ? 32'd2 : 32'd0);
         if (we) check(al ? "R4 lane strobe" : "R1 strobes kept",
                       {28'b0, last_be}, al ? (32'd1 << lane) : {28'b0, be});
      end

      // R9: throttled memory side
      stall_mode = 1'b1;
      txn = 0; lk = 0;
      do_op(1'b1, 32'h2200_0004, 32'h0000_0001, 4'hF, rd);
      check("R9/R4 stalled store", tmem[0], 32'h8000_000A);
      check("R9/R5 stalled store locks", lk, 32'd2);
      do_op(1'b0, 32'h2200_0004, 32'h0, 4'hF, rd);
      check("R9/R3 stalled bit load", rd, 32'd1);
      do_op(1'b0, 32'h2000_0000, 32'h0, 4'hF, rd);
      check("R9/R1 stalled plain load", rd, 32'h8000_000A);
      stall_mode = 1'b0;
      repeat (3) @(negedge clk);

      check("R5 lock never dropped mid-sequence", lock_gap, 32'd0);
      check("R6 ready held low mid-sequence", rdy_viol, 32'd0);
      check("R9 stalled request held stable", stall_viol, 32'd0);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end
endmodule